// File: doc/BRIEF.md
# Coincidence-Addressed Multicast and Simulcast Receiver

This block is one receiver node on a shared, slot-timed bus where destinations are chosen by timing rather than by an address field. A one-clock reference strobe opens a bus frame. The select lane then carries a train of 2N slots, where N is the number of nodes. Every node owns one coincidence slot in that train, and a pulse in that slot is what addresses the node.

In multicast mode, a pulse in the node's own slot arms it. The node then shifts in the N-bit word that follows on the separate message lane. A node that saw no pulse in its slot leaves the message alone. In simulcast mode the message lane is unused. Whether or not a pulse appears in the node's own slot is itself a one-bit message for that node. That bit is moved into an output latch by a strobe that comes one clock after the coincidence slot. Arbitration between senders is handled elsewhere.

Top module: `coin_mcast_rx`

## Requirements
- R1: The clock on which ref_i is high is slot 0 of a frame, and each following clock is the next slot. Node NODE_ID owns select slot 2*NODE_ID. A pulse on sel_i in any other slot never addresses it.
- R2: In multicast mode (simul_i=0 at the frame start), sel_i=1 in the own slot arms the node. The MSG_W bits on msg_i in slots 2N to 2N+MSG_W-1 form word_o, with the first bit received placed in the MSB. valid_o is high for exactly one clock, the clock after the last message slot, and word_o takes the new word on that same clock.
- R3: A multicast frame whose own slot carries no pulse never raises valid_o and leaves word_o unchanged.
- R4: Pulses on sel_i in slots other than the own slot, and activity on msg_i outside the message slots, do not arm the node.
- R5: In simulcast mode (simul_i=1 at the frame start), sim_o takes the sel_i value from the own slot one clock after that slot. It holds that value until the next simulcast strobe.
- R6: In simulcast mode, msg_i is ignored: valid_o stays low and word_o is unchanged.
- R7: The mode is sampled only on the ref_i clock. Changing simul_i during a frame has no effect on that frame.
- R8: A ref_i pulse in the middle of a frame restarts the frame at slot 0 and drops any arming from the interrupted frame.
- R9: After reset, word_o, valid_o and sim_o are all 0.
- R10: word_o changes only on a clock where valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference strobe; marks slot 0 of a frame |
| sel_i | input | 1 | Select-lane bit for the current slot |
| msg_i | input | 1 | Message-lane bit for the current slot |
| simul_i | input | 1 | Mode: 1 = simulcast, 0 = multicast; sampled with ref_i |
| word_o | output | MSG_W | Last multicast word received |
| valid_o | output | 1 | One-clock pulse when word_o has a new word |
| sim_o | output | 1 | Last simulcast bit received |

## Verification
The bench fills every select slot except the node's own slot with pulses. An off-by-one coincidence slot would then arm the node and raise valid_o where none is due. It flips simul_i in the middle of a frame, which catches a design that reads the live mode pin instead of the mode latched at the frame start. It also cuts a frame short with a new reference strobe after the node has been armed. A design that keeps the old arming would then deliver a word nobody sent to it. Simulcast frames with a zero and a one in the own slot, sent while the message lane is busy, show whether the design latches at the wrong time or lets message-lane data leak into word_o.

// File: rtl/cbrx_pkg.sv
package cbrx_pkg;
  typedef enum logic {
    MODE_MCAST = 1'b0,
    MODE_SCAST = 1'b1
  } rx_mode_e;
endpackage

// File: rtl/cbrx_slot_timer.sv
module cbrx_slot_timer #(
  parameter int FRAME = 24,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_i,
  output logic [CW-1:0] slot_o,
  output logic          active_o
);
  localparam logic [CW-1:0] LAST = CW'(FRAME - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n;

  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy_q;
    if (ref_i) begin
      cnt_n  = CW'(1);
      busy_n = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        cnt_n  = '0;
        busy_n = 1'b0;
      end else begin
        cnt_n = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
    end
  end

  assign slot_o   = ref_i ? '0 : cnt_q;
  assign active_o = ref_i | busy_q;
endmodule

// File: rtl/cbrx_coin.sv
module cbrx_coin
  import cbrx_pkg::*;
#(
  parameter int CW        = 5,
  parameter int COIN_SLOT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_i,
  input  logic          active_i,
  input  logic [CW-1:0] slot_i,
  input  logic          sel_i,
  input  rx_mode_e      mode_i,
  output logic          match_o,
  output logic          strobe_o,
  output logic          sim_o
);
  localparam logic [CW-1:0] COIN_S = CW'(COIN_SLOT);

  logic at_coin, is_sc;
  logic match_q, match_n;
  logic strobe_q, strobe_n;
  logic samp_q, samp_n;
  logic sim_q, sim_n;

  assign at_coin = active_i && (slot_i == COIN_S);
  assign is_sc   = (mode_i == MODE_SCAST);

  always_comb begin
    match_n  = match_q;
    if (at_coin)    match_n = sel_i && !is_sc;
    else if (ref_i) match_n = 1'b0;
    strobe_n = at_coin && is_sc;
    samp_n   = at_coin ? sel_i : samp_q;
    sim_n    = strobe_q ? samp_q : sim_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q  <= 1'b0;
      strobe_q <= 1'b0;
      samp_q   <= 1'b0;
      sim_q    <= 1'b0;
    end else begin
      match_q  <= match_n;
      strobe_q <= strobe_n;
      samp_q   <= samp_n;
      sim_q    <= sim_n;
    end
  end

  assign match_o  = match_q;
  assign strobe_o = strobe_q;
  assign sim_o    = sim_q;
endmodule

// File: rtl/cbrx_msg.sv
module cbrx_msg #(
  parameter int CW        = 5,
  parameter int MSG_W     = 8,
  parameter int MSG_FIRST = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic [CW-1:0]    slot_i,
  input  logic             msg_i,
  input  logic             take_i,
  output logic [MSG_W-1:0] word_o,
  output logic             valid_o
);
  localparam logic [CW-1:0] FIRST_S = CW'(MSG_FIRST);
  localparam logic [CW-1:0] LAST_S  = CW'(MSG_FIRST + MSG_W - 1);

  logic             in_msg, shift_en, last;
  logic [MSG_W-1:0] sh_q, sh_n, shifted;
  logic [MSG_W-1:0] word_q, word_n;
  logic             valid_q, valid_n;

  assign in_msg   = active_i && (slot_i >= FIRST_S) && (slot_i <= LAST_S);
  assign shift_en = in_msg && take_i;
  assign last     = slot_i == LAST_S;

  generate
    if (MSG_W == 1) begin : g_one
      assign shifted = msg_i;
    end else begin : g_wide
      assign shifted = {sh_q[MSG_W-2:0], msg_i};
    end
  endgenerate

  always_comb begin
    sh_n    = sh_q;
    word_n  = word_q;
    valid_n = 1'b0;
    if (shift_en) begin
      sh_n = shifted;
      if (last) begin
        word_n  = shifted;
        valid_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      sh_q    <= sh_n;
      word_q  <= word_n;
      valid_q <= valid_n;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/coin_mcast_rx.sv
module coin_mcast_rx
  import cbrx_pkg::*;
#(
  parameter int NODES   = 8,
  parameter int NODE_ID = 3,
  parameter int MSG_W   = NODES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_i,
  input  logic             sel_i,
  input  logic             msg_i,
  input  logic             simul_i,
  output logic [MSG_W-1:0] word_o,
  output logic             valid_o,
  output logic             sim_o
);
  localparam int SEL_SLOTS = 2 * NODES;
  localparam int FRAME     = SEL_SLOTS + MSG_W;
  localparam int CW        = $clog2(FRAME + 1);
  localparam int COIN_SLOT = 2 * NODE_ID;

  logic [CW-1:0] slot;
  logic          active;
  rx_mode_e      mode_q, mode_n, cur_mode;
  logic          coin_match, coin_strobe;

  assign cur_mode = ref_i ? rx_mode_e'(simul_i) : mode_q;

  always_comb begin
    mode_n = mode_q;
    if (ref_i) mode_n = rx_mode_e'(simul_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_MCAST;
    else        mode_q <= mode_n;
  end

  cbrx_slot_timer #(.FRAME(FRAME), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i),
    .slot_o(slot), .active_o(active)
  );

  cbrx_coin #(.CW(CW), .COIN_SLOT(COIN_SLOT)) u_coin (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .active_i(active),
    .slot_i(slot), .sel_i(sel_i), .mode_i(cur_mode),
    .match_o(coin_match), .strobe_o(coin_strobe), .sim_o(sim_o)
  );

  cbrx_msg #(.CW(CW), .MSG_W(MSG_W), .MSG_FIRST(SEL_SLOTS)) u_msg (
    .clk(clk), .rst_n(rst_n), .active_i(active), .slot_i(slot),
    .msg_i(msg_i), .take_i(coin_match && (mode_q == MODE_MCAST)),
    .word_o(word_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/cbrx_checker.sv
module cbrx_checker #(
  parameter int MSG_W     = 8,
  parameter int COIN_SLOT = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_i,
  input logic [MSG_W-1:0] word_o,
  input logic             valid_o,
  input logic             sim_o,
  input logic             strobe,
  input logic             match
);
  AST_VALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R2

  AST_WORD_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(word_o)); // R10

  AST_VALID_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(match)); // R3

  AST_SIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(sim_o)); // R5

  AST_RESTART_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_i && (COIN_SLOT != 0)) |=> !match); // R8
endmodule

bind coin_mcast_rx cbrx_checker #(.MSG_W(MSG_W), .COIN_SLOT(2 * NODE_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .word_o(word_o),
  .valid_o(valid_o), .sim_o(sim_o), .strobe(coin_strobe), .match(coin_match)
);

// File: tb/coin_mcast_rx_test.sv
module coin_mcast_rx_test;
  localparam int NODES   = 8;
  localparam int NODE_ID = 3;
  localparam int MSG_W   = NODES;
  localparam int SEL_N   = 2 * NODES;
  localparam int FRAME   = SEL_N + MSG_W;
  localparam int OWN     = 2 * NODE_ID;

  logic clk, rst_n, ref_i, sel_i, msg_i, simul_i;
  logic [MSG_W-1:0] word_o;
  logic valid_o, sim_o;

  int n_chk = 0, n_fail = 0, n_valid = 0;
  string req = "R9";
  bit finished = 0;

  coin_mcast_rx #(.NODES(NODES), .NODE_ID(NODE_ID), .MSG_W(MSG_W)) uut (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .sel_i(sel_i), .msg_i(msg_i),
    .simul_i(simul_i), .word_o(word_o), .valid_o(valid_o), .sim_o(sim_o)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // behavioural reference model
  int pos = -1;
  bit m_sc = 0, m_hit = 0, pend = 0, pend_v = 0;
  bit q[$];
  logic [MSG_W-1:0] e_word = '0;
  bit e_valid = 0, e_sim = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pos = -1; m_hit = 0; pend = 0; q.delete();
      e_word = '0; e_valid = 0; e_sim = 0;
    end else begin
      e_valid = 0;
      if (pend) begin e_sim = pend_v; pend = 0; end
      if (ref_i) begin
        pos = 0; m_sc = simul_i; m_hit = 0; q.delete();
      end else if (pos >= 0) begin
        pos++;
        if (pos >= FRAME) pos = -1;
      end
      if (pos == OWN) begin
        if (m_sc) begin pend = 1; pend_v = sel_i; end
        else m_hit = sel_i;
      end
      if (pos >= SEL_N && m_hit && !m_sc) begin
        q.push_back(msg_i);
        if (pos == FRAME - 1) begin
          for (int i = 0; i < MSG_W; i++) e_word[MSG_W-1-i] = q[i];
          e_valid = 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (valid_o) n_valid++;
      check(word_o == e_word, req, "word_o", word_o, e_word);
      check(valid_o == e_valid, req, "valid_o", valid_o, e_valid);
      check(sim_o == e_sim, req, "sim_o", sim_o, e_sim);
    end
  end

  task automatic frame(input bit md, input logic [SEL_N-1:0] tr,
                       input logic [MSG_W-1:0] wd, input int len, input bit flip);
    for (int s = 0; s < len; s++) begin
      ref_i   = (s == 0);
      sel_i   = (s < SEL_N) ? tr[s] : 1'b0;
      msg_i   = (s >= SEL_N) ? wd[MSG_W-1-(s-SEL_N)] : 1'b1;
      simul_i = (flip && s > 0) ? ~md : md;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    ref_i = 0; sel_i = 0; msg_i = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_frame(input string tag, input int dv,
                              input logic [MSG_W-1:0] w, input bit s, input int v0);
    check(n_valid - v0 == dv, tag, "valid pulses", n_valid - v0, dv);
    check(word_o == w, tag, "word after frame", word_o, w);
    check(sim_o == s, tag, "sim after frame", sim_o, s);
  endtask

  localparam logic [SEL_N-1:0] OWN_BIT = SEL_N'(1) << OWN;

  initial begin
    int v0;
    rst_n = 0; ref_i = 0; sel_i = 0; msg_i = 0; simul_i = 0;
    repeat (3) @(negedge clk);
    check(word_o == '0 && valid_o == 0 && sim_o == 0, "R9", "reset outputs",
          {word_o, valid_o, sim_o}, 0);
    rst_n = 1;
    idle(2);

    req = "R1"; v0 = n_valid;                      // R1 R2 own slot arms
    frame(0, OWN_BIT, 8'hA5, FRAME, 0); idle(3);
    expect_frame("R2", 1, 8'hA5, 0, v0);

    req = "R4"; v0 = n_valid;                      // R3 R4 all but own slot
    frame(0, ~OWN_BIT, 8'h3C, FRAME, 0); idle(3);
    expect_frame("R3", 0, 8'hA5, 0, v0);

    req = "R2"; v0 = n_valid;
    frame(0, OWN_BIT | 16'h8001, 8'h5A, FRAME, 0); idle(3);
    expect_frame("R2", 1, 8'h5A, 0, v0);

    req = "R5"; v0 = n_valid;                      // R5 R6 simulcast one
    frame(1, OWN_BIT, 8'hFF, FRAME, 0); idle(3);
    expect_frame("R6", 0, 8'h5A, 1, v0);

    req = "R5"; v0 = n_valid;                      // simulcast zero
    frame(1, ~OWN_BIT, 8'h0F, FRAME, 0); idle(3);
    expect_frame("R5", 0, 8'h5A, 0, v0);

    req = "R7"; v0 = n_valid;                      // R7 mode flips mid frame
    frame(0, OWN_BIT, 8'h81, FRAME, 1); idle(3);
    expect_frame("R7", 1, 8'h81, 0, v0);

    req = "R7"; v0 = n_valid;
    frame(1, OWN_BIT, 8'h42, FRAME, 1); idle(3);
    expect_frame("R7", 0, 8'h81, 1, v0);

    req = "R8"; v0 = n_valid;                      // R8 restart drops arming
    frame(0, OWN_BIT, 8'h11, 10, 0);
    frame(0, '0, 8'h77, FRAME, 0); idle(3);
    expect_frame("R8", 0, 8'h81, 1, v0);

    req = "R8"; v0 = n_valid;                      // back-to-back frames
    frame(0, OWN_BIT, 8'hC3, FRAME, 0);
    frame(0, OWN_BIT, 8'h96, FRAME, 0); idle(3);
    expect_frame("R10", 2, 8'h96, 1, v0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule